// File: doc/BRIEF.md
# Dual-Switch Key Event Encoder

This block serves one key that has two active-low contacts a short distance apart. The key contact is the main one, and the velocity contact is the second one along the travel. Both levels arrive already synchronised to the block clock. The block keeps the levels it last reported. When the present levels differ from them, it forms a one-byte type code and pulses a request for one clock. The request goes to the neighbouring relay node, together with the type code and a hop count that starts at one.

The type code records two things: which contact moved, and whether that contact is now closed or open. When both contacts move in the same sampled cycle, only the key contact is reported. The stored levels then take both present values, so the velocity movement in that cycle never produces a message of its own. Debouncing and any timing between the two contacts are handled elsewhere.

Top module: `dual_key_event_encoder`

## Requirements
- R1: While reset is high, msg_req is 0, msg_type is 8'h00 and msg_count is 0. The stored levels load from the present inputs during reset, so no request follows reset release even when a contact is held closed.
- R2: In every reported type byte, bit 7 is 1 and bits 4..0 are 0.
- R3: Type bit 6 is 0 when the key contact (key_n) caused the event and 1 when the velocity contact (vel_n) caused it.
- R4: Type bit 5 is 1 when the reported contact is now low (closed) and 0 when it is now high (open). Expected codes: key close 8'hA0, key open 8'h80, velocity close 8'hE0, velocity open 8'hC0.
- R5: msg_count is 1 whenever msg_req is high.
- R6: A level change sampled at clock edge k raises msg_req for exactly the cycle after edge k. msg_type and msg_count hold their last values until the next event.
- R7: When both contacts change in the same sampled cycle, the event reports the key contact.
- R8: In the case of R7, the velocity change is absorbed: no second request follows for it.
- R9: With no change on either contact, msg_req stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| key_n | input | 1 | Key contact level, low when closed, already synchronised |
| vel_n | input | 1 | Velocity contact level, low when closed, already synchronised |
| msg_req | output | 1 | One-cycle request for the relay node |
| msg_type | output | 8 | Type byte of the latest event |
| msg_count | output | COUNT_W | Hop count of the latest event (always 1) |

## Verification
The assertions assume that both contact inputs change only between clock edges and are never unknown once reset is released. They also assume that reset is held for at least one edge, so that the stored levels start equal to the inputs. The directed bench drives every input change on the falling edge and holds reset for several cycles while the contacts are at chosen levels. It then samples one time unit after each rising edge. This keeps every stimulus inside those assumptions, including the case of both contacts changing together and contacts that toggle on consecutive cycles.

// File: rtl/kev_pkg.sv
package kev_pkg;

    localparam int unsigned TYPE_W  = 8;
    localparam int unsigned SPARE_W = 5;

    typedef enum logic {
        SRC_KEY = 1'b0,
        SRC_VEL = 1'b1
    } src_e;

    // Layout of the type byte: marker, source, closed flag, spare bits.
    typedef struct packed {
        logic               marker;
        src_e               src;
        logic               closed;
        logic [SPARE_W-1:0] spare;
    } type_byte_t;

    // Sampled contact levels, low means closed.
    typedef struct packed {
        logic key_n;
        logic vel_n;
    } lines_t;

    // Result of comparing present and stored levels.
    typedef struct packed {
        logic hit;
        src_e src;
        logic closed;
    } event_t;

    function automatic type_byte_t pack_type(input src_e s, input logic closed);
        type_byte_t t;
        t.marker = 1'b1;
        t.src    = s;
        t.closed = closed;
        t.spare  = '0;
        return t;
    endfunction

endpackage

// File: rtl/kev_level_store.sv
module kev_level_store
    import kev_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  lines_t now_lv,
    input  logic   take,
    output lines_t prev_lv
);

    // Reset loads the live levels, so nothing is reported at start.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lv <= now_lv;
        end else if (take) begin
            prev_lv <= now_lv;
        end
    end

endmodule

// File: rtl/kev_change_pick.sv
module kev_change_pick
    import kev_pkg::*;
(
    input  lines_t now_lv,
    input  lines_t prev_lv,
    output event_t ev
);

    logic key_moved;
    logic vel_moved;

    assign key_moved = now_lv.key_n ^ prev_lv.key_n;
    assign vel_moved = now_lv.vel_n ^ prev_lv.vel_n;

    // The key contact wins when both moved together.
    always_comb begin
        ev.hit = key_moved | vel_moved;
        if (key_moved) begin
            ev.src    = SRC_KEY;
            ev.closed = ~now_lv.key_n;
        end else begin
            ev.src    = SRC_VEL;
            ev.closed = ~now_lv.vel_n;
        end
    end

endmodule

// File: rtl/kev_msg_reg.sv
module kev_msg_reg
    import kev_pkg::*;
#(
    parameter int unsigned COUNT_W   = 8,
    parameter int unsigned HOP_START = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  event_t             ev,
    output logic               req,
    output logic [TYPE_W-1:0]  type_byte,
    output logic [COUNT_W-1:0] count_byte
);

    localparam logic [COUNT_W-1:0] HOP_INIT = COUNT_W'(HOP_START);

    type_byte_t next_type;

    always_comb begin
        next_type = pack_type(ev.src, ev.closed);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req        <= 1'b0;
            type_byte  <= '0;
            count_byte <= '0;
        end else begin
            req <= ev.hit;
            if (ev.hit) begin
                type_byte  <= next_type;
                count_byte <= HOP_INIT;
            end
        end
    end

endmodule

// File: rtl/dual_key_event_encoder.sv
module dual_key_event_encoder
    import kev_pkg::*;
#(
    parameter int unsigned COUNT_W   = 8,
    parameter int unsigned HOP_START = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               key_n,
    input  logic               vel_n,
    output logic               msg_req,
    output logic [7:0]         msg_type,
    output logic [COUNT_W-1:0] msg_count
);

    lines_t now_lv;
    lines_t prev_lv;
    event_t ev;

    assign now_lv.key_n = key_n;
    assign now_lv.vel_n = vel_n;

    kev_level_store u_store (
        .clk     (clk),
        .rst     (rst),
        .now_lv  (now_lv),
        .take    (ev.hit),
        .prev_lv (prev_lv)
    );

    kev_change_pick u_pick (
        .now_lv  (now_lv),
        .prev_lv (prev_lv),
        .ev      (ev)
    );

    kev_msg_reg #(
        .COUNT_W   (COUNT_W),
        .HOP_START (HOP_START)
    ) u_msg (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .req        (msg_req),
        .type_byte  (msg_type),
        .count_byte (msg_count)
    );

endmodule

// File: rtl/dual_key_event_encoder_chk.sv
module dual_key_event_encoder_chk #(
    parameter int unsigned COUNT_W   = 8,
    parameter int unsigned HOP_START = 1
) (
    input logic               clk,
    input logic               rst,
    input logic               key_n,
    input logic               vel_n,
    input logic               msg_req,
    input logic [7:0]         msg_type,
    input logic [COUNT_W-1:0] msg_count
);

    // R2: fixed bits of every reported type byte
    p_fixed_bits_r2: assert property (@(posedge clk) disable iff (rst)
        msg_req |-> (msg_type[7] && msg_type[4:0] == 5'b0));

    // R5: hop count is one on every request
    p_count_one_r5: assert property (@(posedge clk) disable iff (rst)
        msg_req |-> (msg_count == COUNT_W'(HOP_START)));

    // R9: no movement, no request
    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (key_n == $past(key_n) && vel_n == $past(vel_n)) |=> !msg_req);

    // R7, R3: a key movement is always reported as a key event
    p_key_first_r7: assert property (@(posedge clk) disable iff (rst)
        (key_n != $past(key_n)) |=> (msg_req && !msg_type[6]));

    // R4: closed flag matches the key level for key events
    p_key_polarity_r4: assert property (@(posedge clk) disable iff (rst)
        (msg_req && !msg_type[6]) |-> (msg_type[5] == !$past(key_n)));

    // R4: closed flag matches the velocity level for velocity events
    p_vel_polarity_r4: assert property (@(posedge clk) disable iff (rst)
        (msg_req && msg_type[6]) |-> (msg_type[5] == !$past(vel_n)));

    // R6: outputs hold while no request is raised
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!msg_req && !$past(rst)) |-> ($stable(msg_type) && $stable(msg_count)));

endmodule

bind dual_key_event_encoder dual_key_event_encoder_chk #(
    .COUNT_W   (COUNT_W),
    .HOP_START (HOP_START)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .key_n     (key_n),
    .vel_n     (vel_n),
    .msg_req   (msg_req),
    .msg_type  (msg_type),
    .msg_count (msg_count)
);

// File: tb/dual_key_event_encoder_tb.sv
`timescale 1ns/1ps
module dual_key_event_encoder_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_n = 1'b1;
    logic       vel_n = 1'b1;
    logic       msg_req;
    logic [7:0] msg_type;
    logic [7:0] msg_count;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dual_key_event_encoder u_dut (
        .clk       (clk),
        .rst       (rst),
        .key_n     (key_n),
        .vel_n     (vel_n),
        .msg_req   (msg_req),
        .msg_type  (msg_type),
        .msg_count (msg_count)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive levels on the falling edge, sample just after the next rising edge.
    task automatic apply(input logic k, input logic v);
        @(negedge clk);
        key_n = k;
        vel_n = v;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_event(input string tag, input logic [7:0] typ);
        check({tag, " req"}, {7'b0, msg_req}, 8'h01);
        check({tag, " type R2 R3 R4"}, msg_type, typ);
        check({tag, " count R5"}, msg_count, 8'h01);
    endtask

    task automatic expect_quiet(input string tag);
        check({tag, " no req"}, {7'b0, msg_req}, 8'h00);
    endtask

    task automatic do_reset(input logic k, input logic v);
        @(negedge clk);
        rst   = 1'b1;
        key_n = k;
        vel_n = v;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset req", {7'b0, msg_req}, 8'h00);
        check("R1 reset type", msg_type, 8'h00);
        check("R1 reset count", msg_count, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        expect_quiet("R1 after release");
        @(posedge clk);
        #1;
        expect_quiet("R1 after release 2");
    endtask

    task automatic t_key_cycle;
        apply(1'b0, 1'b1);
        expect_event("R4 key close", 8'hA0);
        apply(1'b0, 1'b1);
        expect_quiet("R6 single pulse");
        check("R6 type held", msg_type, 8'hA0);
        check("R6 count held", msg_count, 8'h01);
        apply(1'b1, 1'b1);
        expect_event("R4 key open", 8'h80);
        apply(1'b1, 1'b1);
        expect_quiet("R9 idle");
    endtask

    task automatic t_vel_cycle;
        apply(1'b1, 1'b0);
        expect_event("R3 vel close", 8'hE0);
        apply(1'b1, 1'b0);
        expect_quiet("R6 vel single pulse");
        apply(1'b0, 1'b0);
        expect_event("R3 key after vel", 8'hA0);
        apply(1'b0, 1'b1);
        expect_event("R3 vel open", 8'hC0);
        apply(1'b1, 1'b1);
        expect_event("R4 key open", 8'h80);
        apply(1'b1, 1'b1);
        expect_quiet("R9 idle vel");
    endtask

    task automatic t_both_change;
        apply(1'b0, 1'b0);
        expect_event("R7 both close", 8'hA0);
        apply(1'b0, 1'b0);
        expect_quiet("R8 vel close absorbed");
        check("R8 type kept", msg_type, 8'hA0);
        apply(1'b1, 1'b1);
        expect_event("R7 both open", 8'h80);
        apply(1'b1, 1'b1);
        expect_quiet("R8 vel open absorbed");
    endtask

    task automatic t_back_to_back;
        apply(1'b0, 1'b1);
        expect_event("R6 toggle 1", 8'hA0);
        apply(1'b1, 1'b1);
        expect_event("R6 toggle 2", 8'h80);
        apply(1'b1, 1'b0);
        expect_event("R6 toggle 3", 8'hE0);
        apply(1'b1, 1'b1);
        expect_event("R6 toggle 4", 8'hC0);
        apply(1'b1, 1'b1);
        expect_quiet("R9 after toggles");
    endtask

    initial begin
        do_reset(1'b1, 1'b1);
        t_key_cycle();
        t_vel_cycle();
        t_both_change();
        t_back_to_back();
        do_reset(1'b0, 1'b0);
        apply(1'b0, 1'b1);
        expect_event("R1 held then vel open", 8'hC0);
        apply(1'b1, 1'b1);
        expect_event("R1 held then key open", 8'h80);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule